// File: doc/BRIEF.md
# Signed Double-Length Arithmetic Left Shifter

This unit performs an arithmetic left shift on a 64-bit two's-complement value. The value is held in an even/odd pair of 32-bit general registers. The even register supplies the upper word and the odd register supplies the lower word. The sign bit stays in place. The 63 bits below it move left as one field, and zeros enter on the right.

The shift count comes from the low six bits of an address-sized operand, so any count from 0 to 63 can be requested. The unit also does the following:

- It reports whether any significant bit was lost.
- It raises an overflow interrupt request when the mask input allows it.
- It produces a 2-bit condition code: zero, negative, positive or overflow.

A count of zero gives a combined sign and zero test of the full 64-bit pair.

The register-pair specifier must name an even register. An odd specifier is reported as a specification error. In that case the result and condition code stay as they were.

Each request is one cycle wide, marked by `in_valid`. Results appear in registers one clock later.

Top module: `dshl_unit`

## Requirements
- R1: When `in_valid` is high and bit 0 of `pair_sel` is 1, the following hold on the next cycle:
  - `spec_err` is 1, while `out_valid` and `ovf_irq` are 0.
  - `res_hi`, `res_lo` and `cc` keep their previous values.
- R2: The operand is `{word_hi, word_lo}`, with bit 63 as the most significant bit. The result is returned as `{res_hi, res_lo}` in the same bit order.
- R3: The shift count is `shift_addr[5:0]`. Bits 23..6 of `shift_addr` have no effect on any output.
- R4: Bit 63 of the result equals bit 63 of the operand for every count.
- R5: Result bits 62..0 are operand bits 62..0 shifted left by the count. Bit 31 of `word_lo` moves into `res_hi` like any other numeric bit.
- R6: The lowest `count` result bits are zero.
- R7: Overflow is detected when any bit shifted out of bit position 62 differs from the sign. This is the same as operand bits 63 down to 63-count not being all equal. On overflow, `cc` = 3.
- R8: `ovf_irq` pulses for one cycle with the result only when overflow occurs and `ovf_mask` was 1 with the request.
- R9: Without overflow, `cc` is set as follows:
  - 0 when the 64-bit result is zero.
  - 1 when the result is negative (bit 63 is 1).
  - 2 when the result is positive and nonzero.
- R10: A count of 0 returns the operand unchanged. It never flags overflow, and `cc` still encodes the sign and zero state.
- R11: Outputs are registered. `out_valid` is high exactly in the cycle after an accepted (even) request. On overflow, the result is still the shifted numeric bits under the original sign.
- R12: While `rst` is high, all outputs are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one cycle per operation |
| pair_sel | input | 4 | Register-pair specifier; must be even |
| word_hi | input | 32 | Even register word, upper half of operand |
| word_lo | input | 32 | Odd register word, lower half of operand |
| shift_addr | input | 24 | Computed address; low six bits give the count |
| ovf_mask | input | 1 | Fixed-point overflow interrupt enable |
| out_valid | output | 1 | Result strobe |
| res_hi | output | 32 | Shifted upper word |
| res_lo | output | 32 | Shifted lower word |
| cc | output | 2 | Condition code: 0 zero, 1 negative, 2 positive, 3 overflow |
| ovf_irq | output | 1 | Overflow interrupt request |
| spec_err | output | 1 | Specification error (odd pair specifier) |

## Verification
The bench uses several kinds of input, each targeting a different part of the logic:

- **Fully random 64-bit operands.** These almost always overflow, so they show whether the original sign is kept and the numeric bits are still shifted correctly.
- **Sign-extended operands with random counts.** These fall on both sides of the overflow boundary, so they separate a correct width-dependent overflow test from an off-by-one one.
- **Directed cases.** These cover:
  - count 0 on zero, negative and positive values;
  - a one-bit shift carrying bit 31 of the low word across the word boundary;
  - counts 62 and 63 on +1 and -1;
  - high address bits set;
  - overflow with the mask off.
- **Odd specifiers interleaved with the other cases.** These show that a rejected request leaves the previous result and condition code untouched.

// File: rtl/dshl_pkg.sv
`timescale 1ns/1ps
package dshl_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 24;
    localparam int SEL_W  = 4;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2,
        CC_OVF  = 2'd3
    } cc_e;

    typedef struct packed {
        logic ovf;
        logic is_zero;
        logic is_neg;
    } shift_flags_t;

    function automatic cc_e pick_cc(input shift_flags_t f);
        if (f.ovf)          return CC_OVF;
        else if (f.is_zero) return CC_ZERO;
        else if (f.is_neg)  return CC_NEG;
        else                return CC_POS;
    endfunction

endpackage

// File: rtl/dshl_decode.sv
`timescale 1ns/1ps
module dshl_decode #(
    parameter int SEL_W  = dshl_pkg::SEL_W,
    parameter int ADDR_W = dshl_pkg::ADDR_W,
    parameter int CNT_W  = 6
) (
    input  logic              in_valid,
    input  logic [SEL_W-1:0]  pair_sel,
    input  logic [ADDR_W-1:0] shift_addr,
    output logic              go,
    output logic              bad,
    output logic [CNT_W-1:0]  count
);
    // Only the pair parity and the low count bits matter.
    logic unused_bits;
    assign unused_bits = ^{pair_sel[SEL_W-1:1], shift_addr[ADDR_W-1:CNT_W]};

    assign go    = in_valid & ~pair_sel[0];
    assign bad   = in_valid &  pair_sel[0];
    assign count = shift_addr[CNT_W-1:0];
endmodule

// File: rtl/dshl_core.sv
`timescale 1ns/1ps
module dshl_core
    import dshl_pkg::*;
#(
    parameter int WORD_W = dshl_pkg::WORD_W,
    localparam int DW    = 2 * WORD_W,
    localparam int CNT_W = $clog2(DW)
) (
    input  logic [WORD_W-1:0] word_hi,
    input  logic [WORD_W-1:0] word_lo,
    input  logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo,
    output shift_flags_t      flags
);
    localparam logic [DW-1:0] LOW_ALL  = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SIGN_BIT = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] opnd;
    logic          sign;
    logic [DW-2:0] shifted;
    logic [DW-1:0] keep_low;
    logic [DW-1:0] watch;
    logic [DW-1:0] differ;
    logic [DW-1:0] result;

    assign opnd    = {word_hi, word_lo};
    assign sign    = opnd[DW-1];
    assign shifted = opnd[DW-2:0] << count;

    // Bits 62 down to 63-count must all match the sign.
    assign keep_low = LOW_ALL >> count;
    assign watch    = ~(keep_low | SIGN_BIT);
    assign differ   = opnd ^ {DW{sign}};

    assign result  = {sign, shifted};
    assign res_hi  = result[DW-1:WORD_W];
    assign res_lo  = result[WORD_W-1:0];

    assign flags.ovf     = |(differ & watch);
    assign flags.is_zero = ~|result;
    assign flags.is_neg  = sign;
endmodule

// File: rtl/dshl_unit.sv
`timescale 1ns/1ps
module dshl_unit
    import dshl_pkg::*;
#(
    parameter int WORD_W = dshl_pkg::WORD_W,
    parameter int ADDR_W = dshl_pkg::ADDR_W,
    parameter int SEL_W  = dshl_pkg::SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SEL_W-1:0]  pair_sel,
    input  logic [WORD_W-1:0] word_hi,
    input  logic [WORD_W-1:0] word_lo,
    input  logic [ADDR_W-1:0] shift_addr,
    input  logic              ovf_mask,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo,
    output logic [1:0]        cc,
    output logic              ovf_irq,
    output logic              spec_err
);
    localparam int CNT_W = $clog2(2 * WORD_W);

    logic              go;
    logic              bad;
    logic [CNT_W-1:0]  count;
    logic [WORD_W-1:0] nxt_hi;
    logic [WORD_W-1:0] nxt_lo;
    shift_flags_t      flags;

    logic              vld_q;
    logic              err_q;
    logic              irq_q;
    logic [WORD_W-1:0] hi_q;
    logic [WORD_W-1:0] lo_q;
    cc_e               cc_q;

    dshl_decode #(
        .SEL_W (SEL_W),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) i_decode (
        .in_valid  (in_valid),
        .pair_sel  (pair_sel),
        .shift_addr(shift_addr),
        .go        (go),
        .bad       (bad),
        .count     (count)
    );

    dshl_core #(
        .WORD_W(WORD_W)
    ) i_core (
        .word_hi(word_hi),
        .word_lo(word_lo),
        .count  (count),
        .res_hi (nxt_hi),
        .res_lo (nxt_lo),
        .flags  (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            err_q <= 1'b0;
            irq_q <= 1'b0;
            hi_q  <= '0;
            lo_q  <= '0;
            cc_q  <= CC_ZERO;
        end else begin
            vld_q <= go;
            err_q <= bad;
            irq_q <= go & flags.ovf & ovf_mask;
            if (go) begin
                hi_q <= nxt_hi;
                lo_q <= nxt_lo;
                cc_q <= pick_cc(flags);
            end
        end
    end

    assign out_valid = vld_q;
    assign spec_err  = err_q;
    assign ovf_irq   = irq_q;
    assign res_hi    = hi_q;
    assign res_lo    = lo_q;
    assign cc        = cc_q;
endmodule

// File: rtl/dshl_chk.sv
`timescale 1ns/1ps
module dshl_chk #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 24,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [SEL_W-1:0]  pair_sel,
    input logic [WORD_W-1:0] word_hi,
    input logic [WORD_W-1:0] word_lo,
    input logic [ADDR_W-1:0] shift_addr,
    input logic              ovf_mask,
    input logic              out_valid,
    input logic [WORD_W-1:0] res_hi,
    input logic [WORD_W-1:0] res_lo,
    input logic [1:0]        cc,
    input logic              ovf_irq,
    input logic              spec_err
);
    AST_SPEC_REJECT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pair_sel[0]) |=> (spec_err && !out_valid && !ovf_irq)); // R1

    AST_SPEC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pair_sel[0]) |=> ($stable(res_hi) && $stable(res_lo) && $stable(cc))); // R1

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pair_sel[0]) |=> (res_hi[WORD_W-1] == $past(word_hi[WORD_W-1]))); // R4

    AST_LOW_FILL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pair_sel[0] && shift_addr[5:0] != 6'd0) |=> (res_lo[0] == 1'b0)); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        ovf_irq |-> (out_valid && cc == 2'd3 && $past(ovf_mask))); // R8

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pair_sel[0] && shift_addr[5:0] == 6'd0)
        |=> ({res_hi, res_lo} == $past({word_hi, word_lo}) && cc != 2'd3)); // R10

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && !pair_sel[0])); // R11
endmodule

bind dshl_unit dshl_chk #(
    .WORD_W(WORD_W),
    .ADDR_W(ADDR_W),
    .SEL_W (SEL_W)
) i_dshl_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .pair_sel  (pair_sel),
    .word_hi   (word_hi),
    .word_lo   (word_lo),
    .shift_addr(shift_addr),
    .ovf_mask  (ovf_mask),
    .out_valid (out_valid),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .cc        (cc),
    .ovf_irq   (ovf_irq),
    .spec_err  (spec_err)
);

// File: tb/test_dshl_unit.sv
`timescale 1ns/1ps
module test_dshl_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  pair_sel = '0;
    logic [31:0] word_hi = '0;
    logic [31:0] word_lo = '0;
    logic [23:0] shift_addr = '0;
    logic        ovf_mask = 1'b0;
    logic        out_valid;
    logic [31:0] res_hi;
    logic [31:0] res_lo;
    logic [1:0]  cc;
    logic        ovf_irq;
    logic        spec_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] exp_res = '0;
    logic [1:0]  exp_cc  = '0;

    always #2.5 clk = ~clk;

    dshl_unit i_dshl_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .pair_sel(pair_sel),
        .word_hi(word_hi), .word_lo(word_lo), .shift_addr(shift_addr),
        .ovf_mask(ovf_mask), .out_valid(out_valid), .res_hi(res_hi),
        .res_lo(res_lo), .cc(cc), .ovf_irq(ovf_irq), .spec_err(spec_err)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bit-serial reference: one position per step, overflow on any lost bit unlike the sign.
    function automatic logic [64:0] ref_shift(input logic [63:0] v, input int cnt);
        logic s = v[63];
        logic o = 1'b0;
        for (int i = 0; i < cnt; i++) begin
            if (v[62] != s) o = 1'b1;
            v[62:0] = {v[61:0], 1'b0};
        end
        return {o, v};
    endfunction

    function automatic logic [1:0] ref_cc(input logic o, input logic [63:0] v);
        if (o)            return 2'd3;
        else if (v == 0)  return 2'd0;
        else if (v[63])   return 2'd1;
        else              return 2'd2;
    endfunction

    task automatic run_op(input logic [31:0] hi, input logic [31:0] lo,
                          input logic [23:0] addr, input logic [3:0] sel,
                          input logic mask, input string tag);
        logic [64:0] r;
        @(negedge clk);
        word_hi = hi; word_lo = lo; shift_addr = addr;
        pair_sel = sel; ovf_mask = mask; in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        if (sel[0]) begin
            chk(spec_err && !out_valid && !ovf_irq, {"R1 flags ", tag},
                {61'd0, spec_err, out_valid, ovf_irq}, 64'd4);
            chk({res_hi, res_lo} == exp_res, {"R1 result held ", tag},
                {res_hi, res_lo}, exp_res);
            chk(cc == exp_cc, {"R1 cc held ", tag}, {62'd0, cc}, {62'd0, exp_cc});
        end else begin
            r = ref_shift({hi, lo}, int'(addr[5:0]));
            exp_res = r[63:0];
            exp_cc  = ref_cc(r[64], r[63:0]);
            chk(out_valid && !spec_err, {"R11 valid ", tag},
                {62'd0, out_valid, spec_err}, 64'd2);
            chk({res_hi, res_lo} == exp_res, {"R2 R4 R5 R6 result ", tag},
                {res_hi, res_lo}, exp_res);
            chk(cc == exp_cc, {"R7 R9 cc ", tag}, {62'd0, cc}, {62'd0, exp_cc});
            chk(ovf_irq == (r[64] & mask), {"R8 irq ", tag},
                {63'd0, ovf_irq}, {63'd0, r[64] & mask});
        end
        @(posedge clk);
        #1;
        chk(!out_valid && !spec_err && !ovf_irq, {"R11 single pulse ", tag},
            {61'd0, out_valid, spec_err, ovf_irq}, 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] h;
        logic [31:0] l;
        logic [5:0]  c;
        logic [3:0]  s;
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        #1;
        chk({out_valid, spec_err, ovf_irq, cc, res_hi, res_lo} == '0, "R12 outputs in reset",
            {res_hi, res_lo}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        run_op(32'h0, 32'h0, 24'h0, 4'd2, 1'b1, "R10 zero test on zero");
        run_op(32'hFFFF_FFF0, 32'h1234_5678, 24'h0, 4'd4, 1'b1, "R10 zero test on negative");
        run_op(32'h0000_0001, 32'h0, 24'h0, 4'd0, 1'b1, "R10 zero test on positive");
        run_op(32'h0000_0000, 32'h8000_0001, 24'h1, 4'd6, 1'b1, "R5 word boundary carry");
        run_op(32'h0, 32'h1, 24'd62, 4'd0, 1'b1, "R7 count 62 no overflow");
        run_op(32'h0, 32'h1, 24'd63, 4'd0, 1'b1, "R7 count 63 overflow");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 24'd63, 4'd8, 1'b1, "R4 R9 minus one by 63");
        run_op(32'h4000_0000, 32'h0, 24'd1, 4'd0, 1'b0, "R8 overflow mask off");
        run_op(32'hC000_0000, 32'h0, 24'd1, 4'd0, 1'b1, "R7 negative at edge no overflow");
        run_op(32'h0000_00F0, 32'hABCD_0000, 24'hFFFF_C3, 4'd2, 1'b1, "R3 high address ignored");
        run_op(32'h7FFF_FFFF, 32'h0, 24'd5, 4'd3, 1'b1, "R1 odd specifier");
        run_op(32'h8000_0000, 32'h0, 24'd4, 4'd0, 1'b1, "R11 overflow keeps shifted");

        for (int i = 0; i < 400; i++) begin
            c = 6'($urandom);
            s = 4'($urandom);
            case ($urandom % 3)
                0: begin h = $urandom; l = $urandom; end
                1: begin
                    h = {32{1'($urandom)}};
                    h[c[4:0] % 8 +: 4] = 4'($urandom);
                    l = $urandom;
                end
                default: begin h = {32{1'($urandom)}}; l = $urandom >> c[4:0]; end
            endcase
            run_op(h, l, {18'($urandom), c}, s, 1'($urandom), "random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule